// File: doc/BRIEF.md
# Bit-Rate Error Monitor

This block watches the raw received data line of a serial receiver. It flags any pair of transitions that arrive closer together than one nominal bit period. Each such pair is one error. The block counts these errors and, when the count reaches a programmable 3-bit threshold, sends a single-cycle rate-error strobe to the mode controller. That controller typically uses the strobe to drop out of a listening phase.

The input is brought into the clock domain through a two-flop synchroniser. The bit period is given as a number of sample clocks. A clear strobe from the preamble-pattern detector restarts the error count. The count also restarts by itself after every strobe, so the next detection cycle begins from zero. Data slicing and clock recovery are not part of this block.

Top module: `rate_err_mon`

## Requirements
- R1: After reset `rate_err` is low and the error count is zero. The first edge after reset is never an error, because no earlier edge exists to measure from.
- R2: `rx_in` passes through two synchroniser flops. Both rising and falling transitions of the synchronised signal are active edges.
- R3: An edge that arrives fewer than `bit_len` sample clocks after the previous edge is one error. A spacing of `bit_len` clocks or more is not an error.
- R4: With `thresh` set to N (1 to 7), the error that brings the count to N raises `rate_err` for exactly one cycle. `rate_err` is high in the cycle after the third rising clock edge that follows the `rx_in` change, and only in that cycle. The count keeps its value between errors, however long the line stays quiet.
- R5: In the cycle a strobe is raised, the count returns to zero. Another N errors then produce another strobe.
- R6: A `thresh` of 0 disables the monitor. No strobe is raised and the count is held at zero.
- R7: `pre_clr` high for one cycle sets the count to zero. An error that falls in the same cycle as `pre_clr` is discarded and raises no strobe.
- R8: If `thresh` is lowered to or below the current count, the next error raises the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Raw received data, asynchronous to clk |
| bit_len | input | TW (8) | Nominal bit period in sample clocks |
| thresh | input | EW (3) | Error count that triggers the strobe; 0 disables it |
| pre_clr | input | 1 | Count clear from the preamble detector |
| rate_err | output | 1 | One-cycle rate-error strobe |

## Verification
The clear strobe and a counted error can fall in the same cycle. In that case the clear takes priority: the error is dropped and the count ends at zero. The bench raises `pre_clr` exactly in the cycle where the synchronised second edge of a short pair is seen. It does this once with threshold 1, where no strobe may appear. It does this again with threshold 2 after one earlier error. There, a single later error must not fire, and only the error after that may fire, which shows that the count was really zeroed and not just paused.

// File: rtl/rate_err_mon.sv
module rate_err_mon #(
  parameter int TW = 8,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic [TW-1:0] bit_len,
  input  logic [EW-1:0] thresh,
  input  logic          pre_clr,
  output logic          rate_err
);

  logic          s1, s2, s3;
  logic [TW-1:0] gap;
  logic [EW-1:0] cnt;
  logic [EW:0]   next_cnt;
  logic          edge_seen, short_gap, armed, hit;

  assign edge_seen = s2 ^ s3;
  assign short_gap = edge_seen && (gap < bit_len);
  assign armed     = (thresh != '0);
  assign next_cnt  = {1'b0, cnt} + 1'b1;
  assign hit       = short_gap && armed && !pre_clr && (next_cnt >= {1'b0, thresh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap <= '1;
    else if (edge_seen)
      gap <= TW'(1);
    else if (gap < bit_len)
      gap <= gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (pre_clr || !armed)
      cnt <= '0;
    else if (short_gap)
      cnt <= hit ? '0 : next_cnt[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rate_err <= 1'b0;
    else
      rate_err <= hit;
  end

endmodule

// File: rtl/rate_err_mon_chk.sv
module rate_err_mon_chk #(
  parameter int TW = 8,
  parameter int EW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] bit_len,
  input logic [EW-1:0] thresh,
  input logic          pre_clr,
  input logic          rate_err,
  input logic          edge_seen,
  input logic [TW-1:0] gap,
  input logic [EW-1:0] cnt
);

  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |=> !rate_err);

  assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> !rate_err);

  assert_slow_edge_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && gap >= bit_len) |=> !rate_err);

  assert_strobe_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> $past(edge_seen));

  assert_count_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> (cnt == '0));

  assert_zero_holds_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |=> (cnt == '0));

endmodule

bind rate_err_mon rate_err_mon_chk #(.TW(TW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .thresh(thresh),
  .pre_clr(pre_clr), .rate_err(rate_err), .edge_seen(edge_seen),
  .gap(gap), .cnt(cnt)
);

// File: tb/sim_rate_err_mon.sv
module sim_rate_err_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b0;
  logic [7:0] bit_len = 8'd16;
  logic [2:0] thresh = 3'd0;
  logic       pre_clr = 1'b0;
  logic       rate_err;

  int errs = 0, checks = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rate_err_mon u0 (.clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bit_len(bit_len),
                   .thresh(thresh), .pre_clr(pre_clr), .rate_err(rate_err));

  always @(negedge clk) if (rate_err) pulses++;

  task automatic chk(string rq, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic tog(int spacing);
    @(negedge clk) rx_in = ~rx_in;
    repeat (spacing - 1) @(negedge clk);
  endtask

  task automatic quiet();
    repeat (40) @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk) pre_clr = 1'b1;
    @(negedge clk) pre_clr = 1'b0;
    quiet();
  endtask

  task automatic t_reset();
    int p0;
    chk("R1 reset strobe", rate_err, 0);
    thresh = 3'd1;
    p0 = pulses;
    tog(5); quiet();
    chk("R1 first edge not an error", pulses - p0, 0);
  endtask

  task automatic t_spacing();
    int p0;
    thresh = 3'd1; clr();
    p0 = pulses;
    tog(16); tog(16); tog(16); quiet();
    chk("R3 spacing equal to bit_len", pulses - p0, 0);
    p0 = pulses;
    tog(15); tog(15); quiet();
    chk("R3 spacing bit_len-1", pulses - p0, 1);
    p0 = pulses;
    tog(4); tog(4); quiet();
    chk("R2 opposite polarity pair", pulses - p0, 1);
  endtask

  task automatic t_latency();
    thresh = 3'd1; clr();
    tog(5);
    @(negedge clk) rx_in = ~rx_in;
    @(negedge clk);
    @(negedge clk); chk("R4 no strobe before third edge", rate_err, 0);
    @(negedge clk); chk("R4 strobe after third edge", rate_err, 1);
    @(negedge clk); chk("R4 strobe one cycle wide", rate_err, 0);
    quiet();
  endtask

  task automatic t_count();
    int p0;
    thresh = 3'd3; clr();
    p0 = pulses;
    tog(5); tog(5); tog(5); quiet();
    chk("R4 two errors below threshold 3", pulses - p0, 0);
    tog(5); tog(5); quiet();
    chk("R4 count kept across quiet line", pulses - p0, 1);
    clr();
    p0 = pulses;
    for (int i = 0; i < 7; i++) tog(5);
    quiet();
    chk("R5 six errors give two strobes", pulses - p0, 2);
  endtask

  task automatic t_zero();
    int p0;
    thresh = 3'd0; clr();
    p0 = pulses;
    for (int i = 0; i < 10; i++) tog(3);
    quiet();
    chk("R6 threshold zero silent", pulses - p0, 0);
    thresh = 3'd2;
    tog(5); tog(5); quiet();
    chk("R6 count held at zero while disabled", pulses - p0, 0);
  endtask

  task automatic t_clear();
    int p0;
    thresh = 3'd3; clr();
    tog(5); tog(5); tog(5); quiet();
    clr();
    p0 = pulses;
    tog(5); tog(5); tog(5); repeat (4) @(negedge clk);
    chk("R7 clear zeroed earlier errors", pulses - p0, 0);
    tog(5); quiet();
    chk("R7 third error after clear fires", pulses - p0, 1);
  endtask

  task automatic coinc_tog();
    @(negedge clk) rx_in = ~rx_in;
    @(negedge clk);
    @(negedge clk) pre_clr = 1'b1;
    @(negedge clk) pre_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_coincide();
    int p0;
    thresh = 3'd1; clr();
    p0 = pulses;
    tog(5); coinc_tog(); quiet();
    chk("R7 clear beats error same cycle", pulses - p0, 0);
    thresh = 3'd2; clr();
    p0 = pulses;
    tog(5); tog(5); coinc_tog(); tog(5); quiet();
    chk("R7 coincident error dropped and count zero", pulses - p0, 0);
    tog(5); tog(5); quiet();
    chk("R7 count resumes after coincident clear", pulses - p0, 1);
  endtask

  task automatic t_lower();
    int p0;
    thresh = 3'd7; clr();
    p0 = pulses;
    tog(5); tog(5); tog(5); tog(5); repeat (4) @(negedge clk);
    chk("R8 three errors below threshold 7", pulses - p0, 0);
    thresh = 3'd2;
    tog(5); quiet();
    chk("R8 lowered threshold fires on next error", pulses - p0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spacing();
    t_latency();
    t_count();
    t_zero();
    t_clear();
    t_coincide();
    t_lower();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule